// File: doc/BRIEF.md
# Data Address Translation with Fault Status

This block turns the virtual address of a load or store into a physical address and a result code in one clock. It first works out the privilege mode that applies to the access. It then checks that the address is well formed. It then tries a kernel-only direct map for one region of the address space. Otherwise it uses the result of a lookup in the translation buffer, which a neighbouring array presents on the same cycle. It checks the per-mode read and write enables and the two trap-on-access bits of the matching entry. Refilling the buffer is left to other logic.

When an access does not succeed, the block captures three values: the offending address, a status word that packs the instruction's opcode, its destination register and six cause flags, and a formatted pointer into the page table. Once captured, these three registers stay frozen until software reads the address register, which the core signals with a strobe. Single-cycle event pulses report read and write hits, misses and violations to external counters.

Top module: `dat_xlate`

## Requirements
- R1: After reset, rsp_valid, fault_locked, every event pulse and the three fault registers are all zero.
- R2: The effective mode is cur_mode when priv_mode is low. When priv_mode is high, it is alt_mode for a request with req_alt set and kernel (0) for other requests. Modes are 0 kernel, 1 executive, 2 supervisor, 3 user, and enable bit n of a permission field belongs to mode n.
- R3: An address whose bits 63:42 are not all equal gives code FAULT (1) and flags bad-address and violation, plus the write flag for a store.
- R4: When sp_enable bit 1 is set and VA[42:41] is 2'b10, the address maps directly: the kernel mode gives code OK (0) with rsp_paddr = VA[40:0]. Any other mode gives code ACV (2) with the violation flag (and the write flag for a store).
- R5: A lookup miss sets the miss flag. It gives code NESTED_MISS (4) when req_pte is set and PRIMARY_MISS (3) otherwise.
- R6: A store whose write enable for the effective mode is clear gives ACV, with the fault-on-write flag copied from the entry. A permitted store to an entry with fault-on-write set gives FAULT with flags write and fault-on-write.
- R7: A load whose read enable is clear gives ACV, with the fault-on-read flag copied from the entry. A permitted load to an entry with fault-on-read set gives FAULT with only the fault-on-read flag.
- R8: A successful translated access returns rsp_paddr = {tlb_ppn, VA[12:0]}.
- R9: The captured status word is {opcode[16:11], dest register[10:6], flags[5:0]}. The flag bits are: 0 write, 1 access violation, 2 fault-on-read, 3 fault-on-write, 4 miss, 5 bad address.
- R10: A non-OK result captures the fault registers only while they are unlocked, and the capture sets the lock. A va_read strobe clears the lock. If a capture and a strobe fall in the same cycle, the capture wins. A strobe that meets a fault while locked drops the fault and unlocks.
- R11: The captured formatted address is ptbr OR (VA[42:13] shifted left by 3).
- R12: Each response raises exactly one of the six event pulses for one cycle. The pulse is chosen by direction (read/write) and by class: hit means OK, miss means either miss code, and violation means FAULT or ACV.
- R13: The response appears on the clock edge after the request. A cycle with no request and no strobe gives rsp_valid low, no event and unchanged fault registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_alt | input | 1 | Access asks for the alternate mode |
| req_pte | input | 1 | Access is itself a page-table entry fetch |
| req_opcode | input | 6 | Opcode of the issuing instruction |
| req_rdst | input | 5 | Destination register number |
| priv_mode | input | 1 | Core is running privileged code |
| cur_mode | input | 2 | Current mode |
| alt_mode | input | 2 | Alternate mode register |
| sp_enable | input | 2 | Direct-map enable bits |
| ptbr | input | 64 | Page-table base for the formatted address |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 28 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_fonr | input | 1 | Entry traps on read |
| tlb_fonw | input | 1 | Entry traps on write |
| va_read | input | 1 | Software reads the fault address register |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | Result code |
| rsp_paddr | output | 41 | Physical address |
| fault_va | output | 64 | Captured fault address |
| fault_stat | output | 17 | Captured status word |
| fault_fmt | output | 64 | Captured formatted address |
| fault_locked | output | 1 | Fault registers frozen |
| ev_rd_hit | output | 1 | Read hit pulse |
| ev_rd_miss | output | 1 | Read miss pulse |
| ev_rd_viol | output | 1 | Read violation pulse |
| ev_wr_hit | output | 1 | Write hit pulse |
| ev_wr_miss | output | 1 | Write miss pulse |
| ev_wr_viol | output | 1 | Write violation pulse |

## Verification
A new fault capture and the software read that releases the lock can land on the same clock edge, and that is where the interlock can go wrong. The bench drives a failing request together with the va_read strobe twice. The first time the registers are already locked, so the fault must be dropped and the lock cleared. The second time the registers are unlocked, so the fault must be captured and the lock must stay set. In both cases the bench compares fault_va, fault_stat and fault_locked with a lock model that it keeps itself.

// File: rtl/dat_pkg.sv
package dat_pkg;
  localparam int VA_BITS = 64;
  localparam int N_FLAGS = 6;
  localparam int FLAG_WR    = 0;
  localparam int FLAG_ACV   = 1;
  localparam int FLAG_FONR  = 2;
  localparam int FLAG_FONW  = 3;
  localparam int FLAG_MISS  = 4;
  localparam int FLAG_BADVA = 5;
  localparam logic [1:0] MODE_KERNEL = 2'd0;

  typedef enum logic [2:0] {
    RES_OK        = 3'd0,
    RES_FAULT     = 3'd1,
    RES_ACV       = 3'd2,
    RES_MISS_PRI  = 3'd3,
    RES_MISS_NEST = 3'd4
  } res_e;

  // upper bits above the implemented width must copy the top implemented bit
  function automatic logic va_canonical(input logic [VA_BITS-1:0] va, input int impl_w);
    logic good;
    good = 1'b1;
    for (int i = 0; i < VA_BITS; i++)
      if (i >= impl_w && va[i] != va[impl_w-1]) good = 1'b0;
    return good;
  endfunction

  // page-table pointer: base OR page number times eight
  function automatic logic [VA_BITS-1:0] va_form(input logic [VA_BITS-1:0] base,
                                                 input logic [VA_BITS-1:0] va,
                                                 input int impl_w, input int shift);
    logic [VA_BITS-1:0] vpn;
    vpn = (va & ((64'd1 << impl_w) - 64'd1)) >> shift;
    return base | (vpn << 3);
  endfunction
endpackage

// File: rtl/dat_mode_sel.sv
module dat_mode_sel
  import dat_pkg::*;
(
  input  logic       priv,
  input  logic       alt_req,
  input  logic [1:0] cur_mode,
  input  logic [1:0] alt_mode,
  output logic [1:0] eff_mode
);
  always_comb begin
    if (priv) eff_mode = alt_req ? alt_mode : MODE_KERNEL;
    else      eff_mode = cur_mode;
  end
endmodule

// File: rtl/dat_check.sv
module dat_check
  import dat_pkg::*;
#(
  parameter int IMPL_VA_W  = 43,
  parameter int PA_W       = 41,
  parameter int PAGE_SHIFT = 13,
  localparam int PPN_W     = PA_W - PAGE_SHIFT
) (
  input  logic [VA_BITS-1:0] vaddr,
  input  logic               write,
  input  logic               pte,
  input  logic [1:0]         eff_mode,
  input  logic [1:0]         sp_en,
  input  logic               tlb_hit,
  input  logic [PPN_W-1:0]   tlb_ppn,
  input  logic [3:0]         tlb_rd_en,
  input  logic [3:0]         tlb_wr_en,
  input  logic               tlb_fonr,
  input  logic               tlb_fonw,
  output res_e               res,
  output logic [N_FLAGS-1:0] flags,
  output logic [PA_W-1:0]    paddr
);
  logic canon, sp_hit, perm, trap;

  always_comb begin
    canon  = va_canonical(vaddr, IMPL_VA_W);
    sp_hit = sp_en[1] && (vaddr[IMPL_VA_W-1 -: 2] == 2'b10);
    perm   = write ? tlb_wr_en[eff_mode] : tlb_rd_en[eff_mode];
    trap   = write ? tlb_fonw : tlb_fonr;
    res    = RES_OK;
    flags  = '0;
    flags[FLAG_WR] = write;
    paddr  = {tlb_ppn, vaddr[PAGE_SHIFT-1:0]};
    if (!canon) begin
      res = RES_FAULT;
      flags[FLAG_BADVA] = 1'b1;
      flags[FLAG_ACV]   = 1'b1;
    end else if (sp_hit) begin
      paddr = vaddr[PA_W-1:0];
      if (eff_mode != MODE_KERNEL) begin
        res = RES_ACV;
        flags[FLAG_ACV] = 1'b1;
      end
    end else if (!tlb_hit) begin
      res = pte ? RES_MISS_NEST : RES_MISS_PRI;
      flags[FLAG_MISS] = 1'b1;
    end else if (!perm) begin
      res = RES_ACV;
      flags[FLAG_ACV] = 1'b1;
      if (write) flags[FLAG_FONW] = tlb_fonw;
      else       flags[FLAG_FONR] = tlb_fonr;
    end else if (trap) begin
      res = RES_FAULT;
      if (write) flags[FLAG_FONW] = 1'b1;
      else       flags[FLAG_FONR] = 1'b1;
    end
  end

  // R5: a miss result always carries the miss cause
  always_comb begin
    if (res == RES_MISS_PRI || res == RES_MISS_NEST)
      a_r5_miss_flag: assert (flags[FLAG_MISS]);
  end

  // R6/R7: a trap cause matches the access direction
  always_comb begin
    if (flags[FLAG_FONW]) a_r6_fonw_store: assert (write);
    if (flags[FLAG_FONR]) a_r7_fonr_load:  assert (!write);
  end
endmodule

// File: rtl/dat_fault_regs.sv
module dat_fault_regs
  import dat_pkg::*;
#(
  parameter int STAT_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_evt,
  input  logic               va_read,
  input  logic [VA_BITS-1:0] va_in,
  input  logic [STAT_W-1:0]  stat_in,
  input  logic [VA_BITS-1:0] fmt_in,
  output logic [VA_BITS-1:0] fault_va,
  output logic [STAT_W-1:0]  fault_stat,
  output logic [VA_BITS-1:0] fault_fmt,
  output logic               locked
);
  logic take;
  assign take = fault_evt && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_va   <= '0;
      fault_stat <= '0;
      fault_fmt  <= '0;
      locked     <= 1'b0;
    end else begin
      if (take) begin
        fault_va   <= va_in;
        fault_stat <= stat_in;
        fault_fmt  <= fmt_in;
      end
      locked <= take ? 1'b1 : (va_read ? 1'b0 : locked);
    end
  end

  a_r10_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked && fault_evt |=> $stable(fault_va) && $stable(fault_stat) && $stable(fault_fmt));
  a_r10_read_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    locked && va_read |=> !locked);
  a_r10_capture_locks: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt && !locked |=> locked && fault_va == $past(va_in));
endmodule

// File: rtl/dat_xlate.sv
module dat_xlate
  import dat_pkg::*;
#(
  parameter int IMPL_VA_W  = 43,
  parameter int PA_W       = 41,
  parameter int PAGE_SHIFT = 13,
  parameter int OP_W       = 6,
  parameter int REG_W      = 5,
  localparam int PPN_W     = PA_W - PAGE_SHIFT,
  localparam int STAT_W    = OP_W + REG_W + N_FLAGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [63:0]        req_vaddr,
  input  logic               req_write,
  input  logic               req_alt,
  input  logic               req_pte,
  input  logic [OP_W-1:0]    req_opcode,
  input  logic [REG_W-1:0]   req_rdst,
  input  logic               priv_mode,
  input  logic [1:0]         cur_mode,
  input  logic [1:0]         alt_mode,
  input  logic [1:0]         sp_enable,
  input  logic [63:0]        ptbr,
  input  logic               tlb_hit,
  input  logic [PPN_W-1:0]   tlb_ppn,
  input  logic [3:0]         tlb_rd_en,
  input  logic [3:0]         tlb_wr_en,
  input  logic               tlb_fonr,
  input  logic               tlb_fonw,
  input  logic               va_read,
  output logic               rsp_valid,
  output logic [2:0]         rsp_code,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [63:0]        fault_va,
  output logic [STAT_W-1:0]  fault_stat,
  output logic [63:0]        fault_fmt,
  output logic               fault_locked,
  output logic               ev_rd_hit,
  output logic               ev_rd_miss,
  output logic               ev_rd_viol,
  output logic               ev_wr_hit,
  output logic               ev_wr_miss,
  output logic               ev_wr_viol
);
  logic [1:0]         eff_mode;
  res_e               res;
  logic [N_FLAGS-1:0] flags;
  logic [PA_W-1:0]    paddr;
  logic               fault_evt, is_ok, is_miss;
  logic [STAT_W-1:0]  stat_word;
  logic [63:0]        fmt_word;

  dat_mode_sel u_mode (
    .priv(priv_mode), .alt_req(req_alt), .cur_mode(cur_mode),
    .alt_mode(alt_mode), .eff_mode(eff_mode)
  );

  dat_check #(.IMPL_VA_W(IMPL_VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_check (
    .vaddr(req_vaddr), .write(req_write), .pte(req_pte), .eff_mode(eff_mode),
    .sp_en(sp_enable), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr),
    .tlb_fonw(tlb_fonw), .res(res), .flags(flags), .paddr(paddr)
  );

  assign is_ok     = (res == RES_OK);
  assign is_miss   = (res == RES_MISS_PRI) || (res == RES_MISS_NEST);
  assign fault_evt = req_valid && !is_ok;
  assign stat_word = {req_opcode, req_rdst, flags};
  assign fmt_word  = va_form(ptbr, req_vaddr, IMPL_VA_W, PAGE_SHIFT);

  dat_fault_regs #(.STAT_W(STAT_W)) u_fregs (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .va_read(va_read),
    .va_in(req_vaddr), .stat_in(stat_word), .fmt_in(fmt_word),
    .fault_va(fault_va), .fault_stat(fault_stat), .fault_fmt(fault_fmt),
    .locked(fault_locked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= '0;
      rsp_paddr  <= '0;
      ev_rd_hit  <= 1'b0;
      ev_rd_miss <= 1'b0;
      ev_rd_viol <= 1'b0;
      ev_wr_hit  <= 1'b0;
      ev_wr_miss <= 1'b0;
      ev_wr_viol <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code  <= 3'(res);
        rsp_paddr <= paddr;
      end
      ev_rd_hit  <= req_valid && !req_write && is_ok;
      ev_rd_miss <= req_valid && !req_write && is_miss;
      ev_rd_viol <= req_valid && !req_write && !is_ok && !is_miss;
      ev_wr_hit  <= req_valid && req_write && is_ok;
      ev_wr_miss <= req_valid && req_write && is_miss;
      ev_wr_viol <= req_valid && req_write && !is_ok && !is_miss;
    end
  end

  a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({ev_rd_hit, ev_rd_miss, ev_rd_viol,
                              ev_wr_hit, ev_wr_miss, ev_wr_viol}) == 1);
  a_r13_no_event_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(ev_rd_hit || ev_rd_miss || ev_rd_viol || ev_wr_hit || ev_wr_miss || ev_wr_viol));
  a_r13_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && !va_read |=> $stable(fault_va) && $stable(fault_locked));
  a_r13_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/tb_dat_xlate.sv
module tb_dat_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_alt = 1'b0, req_pte = 1'b0;
  logic [63:0] req_vaddr = '0, ptbr = '0;
  logic [5:0] req_opcode = '0;
  logic [4:0] req_rdst = '0;
  logic priv_mode = 1'b0;
  logic [1:0] cur_mode = '0, alt_mode = '0, sp_enable = '0;
  logic tlb_hit = 1'b0, tlb_fonr = 1'b0, tlb_fonw = 1'b0, va_read = 1'b0;
  logic [27:0] tlb_ppn = '0;
  logic [3:0] tlb_rd_en = '0, tlb_wr_en = '0;
  logic rsp_valid, fault_locked;
  logic [2:0] rsp_code;
  logic [40:0] rsp_paddr;
  logic [63:0] fault_va, fault_fmt;
  logic [16:0] fault_stat;
  logic ev_rd_hit, ev_rd_miss, ev_rd_viol, ev_wr_hit, ev_wr_miss, ev_wr_viol;

  dat_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_alt(req_alt), .req_pte(req_pte),
    .req_opcode(req_opcode), .req_rdst(req_rdst), .priv_mode(priv_mode),
    .cur_mode(cur_mode), .alt_mode(alt_mode), .sp_enable(sp_enable), .ptbr(ptbr),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
    .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw), .va_read(va_read),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
    .fault_va(fault_va), .fault_stat(fault_stat), .fault_fmt(fault_fmt),
    .fault_locked(fault_locked), .ev_rd_hit(ev_rd_hit), .ev_rd_miss(ev_rd_miss),
    .ev_rd_viol(ev_rd_viol), .ev_wr_hit(ev_wr_hit), .ev_wr_miss(ev_wr_miss),
    .ev_wr_viol(ev_wr_viol)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // stimulus fields
  logic [63:0] s_va, s_ptbr;
  bit s_wr, s_alt, s_pte, s_priv, s_hit, s_fonr, s_fonw;
  logic [1:0] s_cm, s_am, s_sp;
  logic [27:0] s_ppn;
  logic [3:0] s_rde, s_wre;
  logic [5:0] s_op;
  logic [4:0] s_rd;

  // bench copy of the fault registers
  bit exp_lock = 1'b0;
  logic [63:0] exp_fva = '0, exp_fmt = '0;
  logic [16:0] exp_stat = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(output logic [2:0] code, output logic [5:0] fl, output logic [40:0] pa);
    logic [1:0] m;
    bit canon, sp;
    m = s_priv ? (s_alt ? s_am : 2'd0) : s_cm;
    canon = (s_va[63:42] == 22'h0) || (s_va[63:42] == 22'h3FFFFF);
    sp = s_sp[1] && (s_va[42:41] == 2'b10);
    fl = {5'b0, s_wr};
    pa = {s_ppn, s_va[12:0]};
    code = 3'd0;
    if (!canon) begin code = 3'd1; fl[5] = 1'b1; fl[1] = 1'b1; end
    else if (sp) begin
      pa = s_va[40:0];
      if (m != 2'd0) begin code = 3'd2; fl[1] = 1'b1; end
    end else if (!s_hit) begin code = s_pte ? 3'd4 : 3'd3; fl[4] = 1'b1; end
    else if (s_wr) begin
      if (!s_wre[m]) begin code = 3'd2; fl[1] = 1'b1; fl[3] = s_fonw; end
      else if (s_fonw) begin code = 3'd1; fl[3] = 1'b1; end
    end else begin
      if (!s_rde[m]) begin code = 3'd2; fl[1] = 1'b1; fl[2] = s_fonr; end
      else if (s_fonr) begin code = 3'd1; fl[2] = 1'b1; end
    end
  endtask

  task automatic issue(input bit rd_strobe, input string tag);
    logic [2:0] ecode;
    logic [5:0] efl;
    logic [40:0] epa;
    logic [5:0] eev;
    @(negedge clk);
    req_vaddr = s_va; req_write = s_wr; req_alt = s_alt; req_pte = s_pte;
    req_opcode = s_op; req_rdst = s_rd; priv_mode = s_priv; cur_mode = s_cm;
    alt_mode = s_am; sp_enable = s_sp; ptbr = s_ptbr; tlb_hit = s_hit;
    tlb_ppn = s_ppn; tlb_rd_en = s_rde; tlb_wr_en = s_wre; tlb_fonr = s_fonr;
    tlb_fonw = s_fonw; va_read = rd_strobe; req_valid = 1'b1;
    model(ecode, efl, epa);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; va_read = 1'b0;
    if (ecode != 3'd0 && !exp_lock) begin
      exp_fva = s_va;
      exp_stat = {s_op, s_rd, efl};
      exp_fmt = s_ptbr | (64'(s_va[42:13]) << 3);
      exp_lock = 1'b1;
    end else if (rd_strobe) exp_lock = 1'b0;
    eev = '0;
    if (ecode == 3'd0) eev[s_wr ? 2 : 5] = 1'b1;
    else if (ecode >= 3'd3) eev[s_wr ? 1 : 4] = 1'b1;
    else eev[s_wr ? 0 : 3] = 1'b1;
    chk("R13 rsp_valid", 64'(rsp_valid), 64'd1);
    chk(tag, 64'(rsp_code), 64'(ecode));
    if (ecode == 3'd0) chk("R8 paddr", 64'(rsp_paddr), 64'(epa));
    chk("R12 events", 64'({ev_rd_hit, ev_rd_miss, ev_rd_viol, ev_wr_hit, ev_wr_miss, ev_wr_viol}), 64'(eev));
    chk("R10 locked", 64'(fault_locked), 64'(exp_lock));
    chk("R10 fault_va", fault_va, exp_fva);
    chk("R9 fault_stat", 64'(fault_stat), 64'(exp_stat));
    chk("R11 fault_fmt", fault_fmt, exp_fmt);
  endtask

  task automatic unlock();
    @(negedge clk); va_read = 1'b1;
    @(posedge clk);
    @(negedge clk); va_read = 1'b0;
    exp_lock = 1'b0;
  endtask

  task automatic base_fields();
    s_va = 64'h0000_0155_0000_1ABC; s_ptbr = 64'hFFF0_0000_0000_0000;
    s_wr = 0; s_alt = 0; s_pte = 0; s_priv = 0; s_hit = 1; s_fonr = 0; s_fonw = 0;
    s_cm = 2'd0; s_am = 2'd0; s_sp = 2'b00; s_ppn = 28'h0ABCDEF;
    s_rde = 4'hF; s_wre = 4'hF; s_op = 6'h2A; s_rd = 5'h13;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 locked", 64'(fault_locked), 64'd0);
    chk("R1 fault_va", fault_va, 64'd0);
    chk("R1 fault_stat", 64'(fault_stat), 64'd0);
    chk("R1 events", 64'({ev_rd_hit, ev_rd_miss, ev_rd_viol, ev_wr_hit, ev_wr_miss, ev_wr_viol}), 64'd0);
    rst_n = 1'b1;

    // R2, R6, R7: sweep modes, directions, enables and trap bits
    for (int m = 0; m < 64; m++)
      for (int w = 0; w < 2; w++)
        for (int e = 0; e < 16; e++)
          for (int f = 0; f < 2; f++) begin
            int cnt;
            cnt = ((m * 2 + w) * 16 + e) * 2 + f;
            base_fields();
            s_priv = m[5]; s_alt = m[4]; s_cm = 2'(m >> 2); s_am = 2'(m);
            s_wr = w[0]; s_rde = 4'(e); s_wre = ~4'(e);
            s_fonr = f[0]; s_fonw = !f[0]; s_sp = 2'b01;
            s_va = 64'h0000_0155_0000_0000 | (64'(cnt) << 9) | 64'(cnt & 511);
            s_ppn = 28'(cnt * 37 + 5); s_op = 6'(cnt); s_rd = 5'(cnt >> 3);
            s_ptbr = 64'hFFF0_0000_0000_0000 | (64'(cnt) << 40);
            issue(1'b0, "R2 mode/perm code");
            unlock();
          end

    // R3 non-canonical, load and store
    base_fields(); s_va = 64'h0000_0800_0000_0000; issue(1'b0, "R3 badva load"); unlock();
    base_fields(); s_va = 64'h8000_0000_0000_1000; s_wr = 1; issue(1'b0, "R3 badva store"); unlock();

    // R4 direct map
    base_fields(); s_va = 64'hFFFF_FC12_3456_789A; s_sp = 2'b10; issue(1'b0, "R4 superpage kernel");
    base_fields(); s_va = 64'hFFFF_FC12_3456_789A; s_sp = 2'b10; s_cm = 2'd3; s_wr = 1;
    issue(1'b0, "R4 superpage user"); unlock();
    base_fields(); s_va = 64'hFFFF_FC12_3456_789A; s_sp = 2'b01; issue(1'b0, "R4 sp disabled uses tlb");

    // R5 misses
    base_fields(); s_hit = 0; issue(1'b0, "R5 primary miss"); unlock();
    base_fields(); s_hit = 0; s_pte = 1; s_wr = 1; issue(1'b0, "R5 nested miss"); unlock();

    // R6 / R7 directed
    base_fields(); s_wr = 1; s_wre = 4'hE; s_fonw = 1; issue(1'b0, "R6 store acv fonw"); unlock();
    base_fields(); s_wr = 1; s_fonw = 1; issue(1'b0, "R6 store fonw fault"); unlock();
    base_fields(); s_rde = 4'hE; s_fonr = 1; issue(1'b0, "R7 load acv fonr"); unlock();
    base_fields(); s_fonr = 1; issue(1'b0, "R7 load fonr fault"); unlock();

    // R10 lock sequence with same-cycle read and fault
    base_fields(); s_hit = 0; s_va = 64'h0000_0100_0000_2000; issue(1'b0, "R10 first capture");
    base_fields(); s_hit = 0; s_va = 64'h0000_0200_0000_4000; issue(1'b0, "R10 locked drop");
    base_fields(); s_hit = 0; s_va = 64'h0000_0300_0000_6000; issue(1'b1, "R10 read beats locked fault");
    chk("R10 unlocked after read", 64'(fault_locked), 64'd0);
    base_fields(); s_hit = 0; s_va = 64'h0000_0044_0000_8000; s_op = 6'h3F; s_rd = 5'h1F;
    issue(1'b1, "R10 capture beats read");
    chk("R10 relocked", 64'(fault_locked), 64'd1);
    unlock();
    chk("R10 standalone read", 64'(fault_locked), 64'd0);

    // R13 idle cycle
    @(negedge clk);
    chk("R13 idle rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R13 idle fault_va", fault_va, exp_fva);
    chk("R13 idle events", 64'({ev_rd_hit, ev_rd_miss, ev_rd_viol, ev_wr_hit, ev_wr_miss, ev_wr_viol}), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule